// File: doc/BRIEF.md
# Serial Character Transmitter with Break Control

This block turns bytes into asynchronous serial frames on a single output line. A frame carries a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity-position bit, then one or two high stop bits. Parity can be even, odd, forced low, forced high or absent. Two further settings mark the parity position for multidrop links: 0 for a data character and 1 for an address character. Each bit lasts sixteen pulses of an internal 16x rate enable. That enable comes from a 16-bit divisor built from two byte inputs, so one bit lasts 16 times the divisor in clock cycles.

One holding register sits in front of the shift register. A strobe writes a byte into it while the transmitter is enabled and the register is free. A command port enables or disables the transmitter, resets it, and raises or drops a break. An optional clear-to-send gate holds back each new character until an active-low input is asserted.

The state machine has six states. S_IDLE holds the line high. It moves to S_BRK when a break is pending, or to S_START when a held character may go out. S_START moves to S_DATA after one bit time. S_DATA moves to S_PAR after its last data bit when parity is present, and otherwise to S_STOP. S_PAR moves to S_STOP. S_STOP moves back to S_IDLE after one stop bit, or after two when two stop bits are selected. S_BRK drives the line low and returns to S_IDLE when the break is dropped. The reset command sends every state to S_IDLE.

Top module: `uatx_core`

## Requirements
- R1: A frame is a 0 start bit, then data bits LSB first, then the parity bit if present, then stop bits at 1. Every bit lasts 16 x divisor clock cycles, and the line idles at 1.
- R2: `len_sel` picks the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of the written byte are not sent.
- R3: The divisor is {`div_hi`,`div_lo`}. A value of 0 or 1 behaves exactly like 2.
- R4: `par_sel` sets the parity-position bit. 000 gives even parity over the sent data bits and 001 gives odd parity. 010 and 110 give a constant 0, and 011 and 111 give a constant 1. 100 and 101 send no parity bit.
- R5: A command with `cmd[6:4]`=3 aborts the frame in progress, drives the line high, discards the held byte and drops any break. The held byte is never sent.
- R6: A command with `cmd[6:4]`=6 raises a break. The line goes low once the current frame ends and stays low while a held byte waits. A command with `cmd[6:4]`=7 drops the break, and the line returns high before any waiting byte is sent.
- R7: While `cts_gate` is 1, a new frame starts only while `cts_n` is 0. A frame already running is not affected.
- R8: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two.
- R9: `cmd[2]`=1 enables the transmitter and `cmd[3]`=1 disables it; when both are set, disable wins. A write is taken only while `tx_ready` is 1, and any other write is ignored. After a disable, the frame in progress and the held byte are still sent.
- R10: `tx_ready` is 1 when the transmitter is enabled and the holding register is free. `tx_empty` is 1 when nothing is held and the machine is in S_IDLE.
- R11: After reset the line is high, the transmitter is disabled (`tx_ready`=0) and `tx_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_hi | input | 8 | Upper byte of the rate divisor |
| div_lo | input | 8 | Lower byte of the rate divisor |
| len_sel | input | 2 | Data bit count select |
| par_sel | input | 3 | Parity scheme select |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_gate | input | 1 | 1 makes new frames wait for `cts_n` low |
| cts_n | input | 1 | Clear-to-send, active low |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Character to send |
| cmd_stb | input | 1 | Command strobe |
| cmd | input | 8 | Command: [6:4] action code, [3] disable, [2] enable |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
Assertions check on every cycle that rate pulses never come back to back with the smallest divisor and that a full holding register keeps its byte until it is taken or flushed. They also check that a frame only starts from S_IDLE under a satisfied clear-to-send gate, that a reset command leaves the block empty with the line high, and that the line is high whenever the block reports empty. The bench scenarios show the bit-level frame content for each length, parity scheme and stop count. They also show the effective divisor clamp, the ordering of a break against the current frame and a waiting byte, and the draining of queued bytes after a disable.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK
    } tx_state_e;

    localparam logic [2:0] CMD_FLUSH  = 3'h3;
    localparam logic [2:0] CMD_BRK_ON = 3'h6;
    localparam logic [2:0] CMD_BRK_OFF = 3'h7;

    function automatic logic par_present(input logic [2:0] mode);
        return !(mode == 3'b100 || mode == 3'b101);
    endfunction

    function automatic logic par_value(input logic [2:0] mode, input logic [CHAR_W-1:0] d);
        logic v;
        unique case (mode)
            3'b000:  v = ^d;
            3'b001:  v = ~^d;
            3'b011,
            3'b111:  v = 1'b1;
            default: v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt_q;

    assign div_eff = (div < DIV_MIN) ? DIV_MIN : div;
    assign tick    = run && (cnt_q == div_eff - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         accept,
    input  logic         take,
    input  logic         flush,
    output logic         full,
    output logic [W-1:0] data
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (flush) begin
            full_q <= 1'b0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (wr && accept && !full_q) begin
            full_q <= 1'b1;
            data_q <= wdata;
        end
    end

    assign full = full_q;
    assign data = data_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take && !flush) |=> (full_q && $stable(data_q))); // R9

endmodule

// File: rtl/uatx_frame.sv
module uatx_frame
    import uatx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flush,
    input  logic              brk_req,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    input  logic [1:0]        len_sel,
    input  logic [2:0]        par_sel,
    input  logic              two_stop,
    input  logic              cts_gate,
    input  logic              cts_n,
    output logic              take,
    output logic              run,
    output logic              busy,
    output logic              txd
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [2:0]        cnt_q;
    logic [2:0]        nlast_q;
    logic [CHAR_W-1:0] shf_q;
    logic              pbit_q, hasp_q, stop2_q;
    logic              bit_end, cts_ok;
    logic [CHAR_W-1:0] mask, masked;

    assign bit_end = tick && (sub_q == SUB_LAST);
    assign cts_ok  = !cts_gate || !cts_n;
    assign mask    = 8'hFF >> (2'd3 - len_sel);
    assign masked  = hold_data & mask;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        if (flush) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (brk_req) begin
                        state_d = S_BRK;
                    end else if (hold_full && cts_ok) begin
                        state_d = S_START;
                        take    = 1'b1;
                    end
                end
                S_START: if (bit_end) state_d = S_DATA;
                S_DATA: begin
                    if (bit_end && cnt_q == nlast_q) begin
                        state_d = hasp_q ? S_PAR : S_STOP;
                    end
                end
                S_PAR: if (bit_end) state_d = S_STOP;
                S_STOP: begin
                    if (bit_end && !(stop2_q && cnt_q == 3'd0)) begin
                        state_d = S_IDLE;
                    end
                end
                S_BRK: if (!brk_req) state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sub_q   <= '0;
            cnt_q   <= '0;
            nlast_q <= '0;
            shf_q   <= '0;
            pbit_q  <= 1'b0;
            hasp_q  <= 1'b0;
            stop2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sub_q   <= !run ? '0 : (tick ? sub_q + SUB_W'(1) : sub_q);
            if (take) begin
                shf_q   <= masked;
                pbit_q  <= par_value(par_sel, masked);
                hasp_q  <= par_present(par_sel);
                nlast_q <= 3'd4 + {1'b0, len_sel};
                stop2_q <= two_stop;
            end
            if (flush) begin
                cnt_q <= '0;
            end else if (bit_end) begin
                unique case (state_q)
                    S_START: cnt_q <= '0;
                    S_DATA: begin
                        shf_q <= shf_q >> 1;
                        cnt_q <= (cnt_q == nlast_q) ? 3'd0 : cnt_q + 3'd1;
                    end
                    S_STOP:  cnt_q <= cnt_q + 3'd1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    always_comb begin
        run  = 1'b0;
        txd  = 1'b1;
        busy = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE:  txd = 1'b1;
            S_START: begin run = 1'b1; txd = 1'b0;     end
            S_DATA:  begin run = 1'b1; txd = shf_q[0]; end
            S_PAR:   begin run = 1'b1; txd = pbit_q;   end
            S_STOP:  begin run = 1'b1; txd = 1'b1;     end
            S_BRK:   txd = 1'b0;
            default: txd = 1'b1;
        endcase
    end

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && $past(state_q) == S_IDLE) |-> $past(!cts_gate || !cts_n)); // R7

endmodule

// File: rtl/uatx_core.sv
module uatx_core
    import uatx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  div_hi,
    input  logic [7:0]  div_lo,
    input  logic [1:0]  len_sel,
    input  logic [2:0]  par_sel,
    input  logic        two_stop,
    input  logic        cts_gate,
    input  logic        cts_n,
    input  logic        wr_stb,
    input  logic [7:0]  wr_data,
    input  logic        cmd_stb,
    input  logic [7:0]  cmd,
    output logic        txd,
    output logic        tx_ready,
    output logic        tx_empty
);
    logic              en_q, brk_q;
    logic              flush, take, run, tick, busy, hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic [2:0]        code;

    assign code  = cmd[6:4];
    assign flush = cmd_stb && (code == CMD_FLUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else if (cmd_stb) begin
            if (cmd[3]) begin
                en_q <= 1'b0;
            end else if (cmd[2]) begin
                en_q <= 1'b1;
            end
            if (code == CMD_BRK_ON) begin
                brk_q <= 1'b1;
            end else if (code == CMD_BRK_OFF || code == CMD_FLUSH) begin
                brk_q <= 1'b0;
            end
        end
    end

    uatx_baud #(.DIV_W(DIV_W)) i_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (DIV_W'({div_hi, div_lo})),
        .tick  (tick)
    );

    uatx_hold #(.W(CHAR_W)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_stb),
        .wdata  (wr_data),
        .accept (en_q),
        .take   (take),
        .flush  (flush),
        .full   (hold_full),
        .data   (hold_data)
    );

    uatx_frame #(.OVS(OVS)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .flush     (flush),
        .brk_req   (brk_q),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .len_sel   (len_sel),
        .par_sel   (par_sel),
        .two_stop  (two_stop),
        .cts_gate  (cts_gate),
        .cts_n     (cts_n),
        .take      (take),
        .run       (run),
        .busy      (busy),
        .txd       (txd)
    );

    assign tx_ready = en_q && !hold_full;
    assign tx_empty = !busy && !hold_full;

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_empty && txd)); // R5

    AST_EMPTY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R10

endmodule

// File: tb/test_uatx_core.sv
module test_uatx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_hi = 8'h00, div_lo = 8'h02;
    logic [1:0] len_sel = 2'b11;
    logic [2:0] par_sel = 3'b100;
    logic       two_stop = 1'b0, cts_gate = 1'b0, cts_n = 1'b1;
    logic       wr_stb = 1'b0, cmd_stb = 1'b0;
    logic [7:0] wr_data = 8'h00, cmd = 8'h00;
    logic       txd, tx_ready, tx_empty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uatx_core i_uatx_core (
        .clk(clk), .rst_n(rst_n), .div_hi(div_hi), .div_lo(div_lo),
        .len_sel(len_sel), .par_sel(par_sel), .two_stop(two_stop),
        .cts_gate(cts_gate), .cts_n(cts_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .cmd_stb(cmd_stb), .cmd(cmd), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    // {len_sel[1:0], par_sel[2:0], two_stop, data[7:0], expected parity bit}
    localparam logic [14:0] VEC [9] = '{
        {2'b11, 3'b000, 1'b0, 8'hA5, 1'b0},
        {2'b11, 3'b001, 1'b1, 8'h3C, 1'b1},
        {2'b00, 3'b000, 1'b0, 8'hFF, 1'b1},
        {2'b01, 3'b100, 1'b0, 8'h2A, 1'b0},
        {2'b10, 3'b010, 1'b1, 8'h7F, 1'b0},
        {2'b10, 3'b011, 1'b0, 8'h00, 1'b1},
        {2'b11, 3'b110, 1'b0, 8'h55, 1'b0},
        {2'b11, 3'b111, 1'b1, 8'h81, 1'b1},
        {2'b01, 3'b001, 1'b0, 8'hC3, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] c);
        @(negedge clk); cmd_stb = 1'b1; cmd = c;
        @(negedge clk); cmd_stb = 1'b0; cmd = 8'h00;
    endtask

    // Waits for a start bit and compares each bit at its centre.
    task automatic frame(input logic [1:0] len, input logic [2:0] par, input bit st2,
                         input logic [7:0] d, input bit pexp, input int dv, input string req);
        logic [11:0] e = '0;
        logic [11:0] g = '0;
        int n = 0;
        int w = 0;
        e[n] = 1'b0; n++;
        for (int i = 0; i < 5 + int'(len); i++) begin e[n] = d[i]; n++; end
        if (!(par == 3'b100 || par == 3'b101)) begin e[n] = pexp; n++; end
        e[n] = 1'b1; n++;
        if (st2) begin e[n] = 1'b1; n++; end
        while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        repeat (8 * dv) @(negedge clk);
        g[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (16 * dv) @(negedge clk);
            g[k] = txd;
        end
        chk(g == e, req, int'(g), int'(e));
    endtask

    task automatic idle_for(input int cyc, input string req);
        bit low = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) low = 1'b1;
        end
        chk(!low, req, int'(low), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && tx_ready === 1'b0 && tx_empty === 1'b1, "R11 reset state",
            {txd, tx_ready, tx_empty}, 3'b101);

        do_cmd(8'h04);
        chk(tx_ready === 1'b1, "R9 enable", tx_ready, 1);

        // Table of frame formats, divisor 2
        for (int v = 0; v < 9; v++) begin
            len_sel  = VEC[v][14:13];
            par_sel  = VEC[v][12:10];
            two_stop = VEC[v][9];
            wr(VEC[v][8:1]);
            frame(VEC[v][14:13], VEC[v][12:10], VEC[v][9], VEC[v][8:1], VEC[v][0], 2,
                  "R1 R2 R4 R8 frame vector");
        end
        len_sel = 2'b11; par_sel = 3'b100; two_stop = 1'b0;
        idle_for(40, "R1 idle high");

        // R3 divisor clamp and wider divisor
        div_lo = 8'h00;
        wr(8'h6D);
        frame(2'b11, 3'b100, 1'b0, 8'h6D, 1'b0, 2, "R3 divisor 0 acts as 2");
        div_lo = 8'h01;
        wr(8'hB2);
        frame(2'b11, 3'b100, 1'b0, 8'hB2, 1'b0, 2, "R3 divisor 1 acts as 2");
        div_lo = 8'h03;
        wr(8'h4E);
        frame(2'b11, 3'b100, 1'b0, 8'h4E, 1'b0, 3, "R3 divisor 3");
        div_lo = 8'h02;
        idle_for(40, "R3 settle");

        // R10 status with shifter busy and holding register full
        wr(8'h11);
        wr(8'h22);
        chk(tx_ready === 1'b0 && tx_empty === 1'b0, "R10 both full",
            {tx_ready, tx_empty}, 2'b00);
        frame(2'b11, 3'b100, 1'b0, 8'h11, 1'b0, 2, "R10 first of pair");
        frame(2'b11, 3'b100, 1'b0, 8'h22, 1'b0, 2, "R10 second of pair");
        repeat (20) @(negedge clk);
        chk(tx_empty === 1'b1 && tx_ready === 1'b1, "R10 empty after drain",
            {tx_ready, tx_empty}, 2'b11);

        // R5 reset command aborts and drops held byte
        wr(8'h00);
        wr(8'h0F);
        repeat (96) @(negedge clk);
        do_cmd(8'h30);
        chk(txd === 1'b1 && tx_empty === 1'b1 && tx_ready === 1'b1, "R5 flush state",
            {txd, tx_ready, tx_empty}, 3'b111);
        idle_for(400, "R5 held byte not sent");

        // R7 clear-to-send gating
        cts_gate = 1'b1; cts_n = 1'b1;
        wr(8'h5A);
        idle_for(100, "R7 held while cts_n high");
        chk(tx_empty === 1'b0, "R7 byte waiting", tx_empty, 0);
        cts_n = 1'b0;
        frame(2'b11, 3'b100, 1'b0, 8'h5A, 1'b0, 2, "R7 sent after cts_n low");
        cts_gate = 1'b0; cts_n = 1'b1;
        idle_for(20, "R7 settle");

        // R6 break after the current frame, byte waiting behind it
        wr(8'h96);
        do_cmd(8'h60);
        frame(2'b11, 3'b100, 1'b0, 8'h96, 1'b0, 2, "R6 frame before break");
        repeat (64) @(negedge clk);
        chk(txd === 1'b0 && tx_empty === 1'b0, "R6 break low", {txd, tx_empty}, 2'b00);
        wr(8'h3C);
        repeat (64) @(negedge clk);
        chk(txd === 1'b0, "R6 break holds waiting byte", txd, 0);
        do_cmd(8'h70);
        @(negedge clk);
        chk(txd === 1'b1, "R6 break dropped", txd, 1);
        frame(2'b11, 3'b100, 1'b0, 8'h3C, 1'b0, 2, "R6 waiting byte after break");
        idle_for(20, "R6 settle");

        // R9 disable drains queued bytes, later writes ignored
        wr(8'hE1);
        wr(8'h1E);
        do_cmd(8'h08);
        chk(tx_ready === 1'b0, "R9 disabled not ready", tx_ready, 0);
        wr(8'hAA);
        frame(2'b11, 3'b100, 1'b0, 8'hE1, 1'b0, 2, "R9 drain in progress");
        frame(2'b11, 3'b100, 1'b0, 8'h1E, 1'b0, 2, "R9 drain held");
        idle_for(400, "R9 write while disabled ignored");
        chk(tx_empty === 1'b1, "R9 empty after drain", tx_empty, 1);
        do_cmd(8'h0C);
        chk(tx_ready === 1'b0, "R9 disable wins", tx_ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule